// File: doc/BRIEF.md
# Programmable Counter Array

This block is a timing peripheral built around one shared 16-bit up-counter and five identical channels that watch it. The counter steps from one of four clock sources and can be started, stopped, held during core idle and loaded from the register bus. When it wraps from FFFFh to 0000h it sets a sticky wrap flag.

Each channel is configured through its own mode register. In that register it can be set to latch the counter on chosen edges of its input pin, to raise a flag when the counter reaches a 16-bit target (optionally inverting its output pin at that moment), or to produce an 8-bit pulse-width waveform whose duty value is reloaded without glitches at every low-byte rollover. Software sees all state through a byte-wide register bus. One combined interrupt output summarises every enabled flag.

Register map (5-bit byte address): 00h control (bit 0 run, bit 7 wrap flag); 01h setup (bit 0 wrap-interrupt enable, bits 2:1 clock source, bit 3 halt-in-idle); 02h channel flags (bit n = channel n); 03h/04h counter low/high byte; channel n at 08h+3n mode, 09h+3n compare/capture low byte, 0Ah+3n compare/capture high byte. Mode bits: 6 arm (comparator enable), 5 rising-edge capture, 4 falling-edge capture, 3 match, 2 toggle, 1 PWM, 0 channel interrupt enable.

Top module: `ctarr_top`

## Requirements
- R1: After reset the control, setup, flag, counter and channel registers read 00h, every output pin is 0 and the interrupt is low.
- R2: The setup field bits 2:1 picks the counter step source: 0 = one step every 6 peripheral-clock enables, 1 = one step every 2 enables, 2 = one step per timer-0 overflow strobe, 3 = one step per rising edge of the external count input.
- R3: The counter steps only while control bit 0 (run) is 1; with run at 0 it holds its value.
- R4: With setup bit 3 set and the core-idle input high the counter holds; with bit 3 clear the idle input has no effect.
- R5: A step from FFFFh gives 0000h and sets control bit 7. A write with bit 7 = 0 clears it, a write with bit 7 = 1 leaves it unchanged, and it never clears by itself.
- R6: A channel with mode bit 5 latches the counter into its 16-bit compare/capture register and sets its flag on a rising pin edge; mode bit 4 does the same on a falling edge; with both set, either edge latches.
- R7: An armed channel (mode bit 6) with mode bit 3 and not bit 1 sets its flag on the step that makes the counter equal its 16-bit register; with mode bit 2 also set its output pin inverts on that step.
- R8: Writing a channel's low register byte clears mode bit 6; writing its high byte sets it.
- R9: An armed channel in PWM mode (bits 6 and 1) drives its pin 0 while the counter low byte is below its low register byte and 1 otherwise.
- R10: In PWM mode, on each step where the counter low byte rolls from FFh to 00h, the channel low byte is loaded from its high byte.
- R11: Channel flags are cleared by writing 0 to their bit at 02h. Writing 1 has no effect, and a set event in the same cycle as a clear wins.
- R12: The interrupt output is high exactly when the wrap flag is set with setup bit 0, or any channel flag is set with that channel's mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pclk_en | input | 1 | Peripheral clock enable pulse |
| t0_ovf | input | 1 | Timer-0 overflow strobe |
| ext_cnt | input | 1 | External count input |
| core_idle | input | 1 | Core is in idle mode |
| cex_in | input | 5 | Channel capture pins |
| cex_out | output | 5 | Channel output pin levels |
| chan_flag | output | 5 | Channel flags |
| ovf_flag | output | 1 | Counter wrap flag |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the following: the counter holds while stopped or halted in idle, the wrap flag and the channel flags stay set until a clear, writes to the compare bytes disarm and re-arm the comparator, and the PWM low byte takes the high byte at each rollover. The interrupt is also checked to stay low while no flag is set. Only the bench's scenarios can show the step rate of each clock source, the values captured on each edge polarity and the cycle a match toggles the pin. They also show the PWM level against a set of duty and counter values, and that a set event beats a clear written in the same cycle.

// File: rtl/ctarr_pkg.sv
`timescale 1ns/1ps
package ctarr_pkg;

    // channel mode register layout, MSB first: bit 6 down to bit 0
    typedef struct packed {
        logic ecom;   // comparator armed
        logic capp;   // latch on rising pin edge
        logic capn;   // latch on falling pin edge
        logic mat;    // flag on match
        logic tog;    // invert pin on match
        logic pwm;    // pulse-width output
        logic ie;     // channel interrupt enable
    } chan_mode_t;

    typedef enum logic [1:0] {
        SRC_DIV6 = 2'd0,
        SRC_DIV2 = 2'd1,
        SRC_T0   = 2'd2,
        SRC_EXT  = 2'd3
    } src_sel_t;

    localparam int ADR_CTL    = 0;
    localparam int ADR_CFG    = 1;
    localparam int ADR_FLG    = 2;
    localparam int ADR_CNTL   = 3;
    localparam int ADR_CNTH   = 4;
    localparam int CH_BASE    = 8;
    localparam int CH_STRIDE  = 3;

endpackage

// File: rtl/ctarr_timebase.sv
`timescale 1ns/1ps
module ctarr_timebase
    import ctarr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int DIV_SLOW = 6,
    parameter int DIV_FAST = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  src_sel_t              src_i,
    input  logic                  idle_stop_i,
    input  logic                  core_idle_i,
    input  logic                  pclk_en_i,
    input  logic                  t0_ovf_i,
    input  logic                  ext_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    input  logic                  ovf_clr_i,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output logic [2*BYTE_W-1:0]   cnt_next_o,
    output logic                  tick_o,
    output logic                  lo_roll_o,
    output logic                  ovf_o
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int PRE_W = $clog2(DIV_SLOW);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             ext_prev;
        logic             ovf;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic [PRE_W-1:0] lim;
    logic is_div, gate, pre_hit, src_tick, tick;

    always_comb begin
        s_d        = s_q;
        s_d.ext_prev = ext_i;
        lim        = (src_i == SRC_DIV6) ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
        is_div     = (src_i == SRC_DIV6) || (src_i == SRC_DIV2);
        gate       = run_i && !(idle_stop_i && core_idle_i);
        pre_hit    = is_div && pclk_en_i && (s_q.pre >= lim);
        unique case (src_i)
            SRC_T0:  src_tick = t0_ovf_i;
            SRC_EXT: src_tick = ext_i && !s_q.ext_prev;
            default: src_tick = pre_hit;
        endcase
        tick = gate && src_tick;

        if (!gate || !is_div)
            s_d.pre = '0;
        else if (pclk_en_i)
            s_d.pre = pre_hit ? '0 : s_q.pre + 1'b1;

        if (tick)
            s_d.cnt = s_q.cnt + 1'b1;

        if (tick && (&s_q.cnt))
            s_d.ovf = 1'b1;
        else if (ovf_clr_i)
            s_d.ovf = 1'b0;

        if (wr_lo_i)
            s_d.cnt[BYTE_W-1:0] = wdata_i;
        if (wr_hi_i)
            s_d.cnt[CNT_W-1:BYTE_W] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o      = s_q.cnt;
    assign cnt_next_o = s_q.cnt + 1'b1;
    assign tick_o     = tick;
    assign lo_roll_o  = tick && (&s_q.cnt[BYTE_W-1:0]);
    assign ovf_o      = s_q.ovf;

    AST_HALT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(s_q.cnt)); // R3
    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_stop_i && core_idle_i && !wr_lo_i && !wr_hi_i) |=> $stable(s_q.cnt)); // R4
    AST_WRAP_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !ovf_clr_i) |=> s_q.ovf); // R5
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&s_q.cnt) && !wr_lo_i && !wr_hi_i) |=> (s_q.ovf && s_q.cnt == '0)); // R5

endmodule

// File: rtl/ctarr_channel.sv
`timescale 1ns/1ps
module ctarr_channel
    import ctarr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [2*BYTE_W-1:0]   cnt_i,
    input  logic [2*BYTE_W-1:0]   cnt_next_i,
    input  logic                  lo_roll_i,
    input  logic                  cex_i,
    input  logic                  wr_mode_i,
    input  logic                  wr_lo_i,
    input  logic                  wr_hi_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    input  logic                  flag_clr_i,
    output chan_mode_t            mode_o,
    output logic [2*BYTE_W-1:0]   cmp_o,
    output logic                  flag_o,
    output logic                  cex_o
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = $bits(chan_mode_t);

    typedef struct packed {
        chan_mode_t       mode;
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             tog;
        logic             cex_prev;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic rise, fall, cap_evt, match_evt, pwm_on;

    always_comb begin
        s_d          = s_q;
        s_d.cex_prev = cex_i;
        rise      = cex_i && !s_q.cex_prev;
        fall      = !cex_i && s_q.cex_prev;
        cap_evt   = (s_q.mode.capp && rise) || (s_q.mode.capn && fall);
        pwm_on    = s_q.mode.ecom && s_q.mode.pwm;
        match_evt = s_q.mode.ecom && s_q.mode.mat && !s_q.mode.pwm
                    && tick_i && (cnt_next_i == s_q.cmp);

        if (cap_evt)
            s_d.cmp = cnt_i;
        if (match_evt && s_q.mode.tog)
            s_d.tog = !s_q.tog;
        if (pwm_on && lo_roll_i)
            s_d.cmp[BYTE_W-1:0] = s_q.cmp[CNT_W-1:BYTE_W];

        if (cap_evt || match_evt)
            s_d.flag = 1'b1;
        else if (flag_clr_i)
            s_d.flag = 1'b0;

        if (wr_mode_i)
            s_d.mode = chan_mode_t'(wdata_i[MODE_W-1:0]);
        if (wr_lo_i) begin
            s_d.cmp[BYTE_W-1:0] = wdata_i;
            s_d.mode.ecom       = 1'b0;
        end
        if (wr_hi_i) begin
            s_d.cmp[CNT_W-1:BYTE_W] = wdata_i;
            s_d.mode.ecom           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_o = s_q.mode;
    assign cmp_o  = s_q.cmp;
    assign flag_o = s_q.flag;
    assign cex_o  = pwm_on ? (cnt_i[BYTE_W-1:0] >= s_q.cmp[BYTE_W-1:0]) : s_q.tog;

    AST_LO_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> !s_q.mode.ecom); // R8
    AST_HI_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_i |=> s_q.mode.ecom); // R8
    AST_CHAN_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !flag_clr_i) |=> s_q.flag); // R11
    AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && lo_roll_i && !cap_evt && !wr_lo_i && !wr_hi_i && !wr_mode_i)
        |=> (s_q.cmp[BYTE_W-1:0] == $past(s_q.cmp[CNT_W-1:BYTE_W]))); // R10

endmodule

// File: rtl/ctarr_top.sv
`timescale 1ns/1ps
module ctarr_top
    import ctarr_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 5,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               pclk_en,
    input  logic               t0_ovf,
    input  logic               ext_cnt,
    input  logic               core_idle,
    input  logic [NUM_CH-1:0]  cex_in,
    output logic [NUM_CH-1:0]  cex_out,
    output logic [NUM_CH-1:0]  chan_flag,
    output logic               ovf_flag,
    output logic               irq
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic     run;
        logic     ovf_ie;
        src_sel_t src;
        logic     idle_stop;
    } ctl_state_t;

    ctl_state_t c_d, c_q;

    logic sel_ctl, sel_cfg, sel_flg, sel_cntl, sel_cnth;
    logic ovf_clr;
    logic [CNT_W-1:0] cnt, cnt_next;
    logic tick, lo_roll;
    logic [NUM_CH-1:0] flag_clr, ie_vec;
    chan_mode_t        mode_vec [NUM_CH];
    logic [CNT_W-1:0]  cmp_vec  [NUM_CH];

    assign sel_ctl  = bus_we && (bus_addr == ADDR_W'(ADR_CTL));
    assign sel_cfg  = bus_we && (bus_addr == ADDR_W'(ADR_CFG));
    assign sel_flg  = bus_we && (bus_addr == ADDR_W'(ADR_FLG));
    assign sel_cntl = bus_we && (bus_addr == ADDR_W'(ADR_CNTL));
    assign sel_cnth = bus_we && (bus_addr == ADDR_W'(ADR_CNTH));
    assign ovf_clr  = sel_ctl && !bus_wdata[BYTE_W-1];

    always_comb begin
        c_d = c_q;
        if (sel_ctl)
            c_d.run = bus_wdata[0];
        if (sel_cfg) begin
            c_d.ovf_ie    = bus_wdata[0];
            c_d.src       = src_sel_t'(bus_wdata[2:1]);
            c_d.idle_stop = bus_wdata[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    ctarr_timebase #(.BYTE_W(BYTE_W)) tb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (c_q.run),
        .src_i       (c_q.src),
        .idle_stop_i (c_q.idle_stop),
        .core_idle_i (core_idle),
        .pclk_en_i   (pclk_en),
        .t0_ovf_i    (t0_ovf),
        .ext_i       (ext_cnt),
        .wr_lo_i     (sel_cntl),
        .wr_hi_i     (sel_cnth),
        .wdata_i     (bus_wdata),
        .ovf_clr_i   (ovf_clr),
        .cnt_o       (cnt),
        .cnt_next_o  (cnt_next),
        .tick_o      (tick),
        .lo_roll_o   (lo_roll),
        .ovf_o       (ovf_flag)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int A_MODE = CH_BASE + CH_STRIDE * n;
        logic wr_mode, wr_lo, wr_hi;
        assign wr_mode     = bus_we && (bus_addr == ADDR_W'(A_MODE));
        assign wr_lo       = bus_we && (bus_addr == ADDR_W'(A_MODE + 1));
        assign wr_hi       = bus_we && (bus_addr == ADDR_W'(A_MODE + 2));
        assign flag_clr[n] = sel_flg && !bus_wdata[n];
        assign ie_vec[n]   = mode_vec[n].ie;

        ctarr_channel #(.BYTE_W(BYTE_W)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .cnt_i      (cnt),
            .cnt_next_i (cnt_next),
            .lo_roll_i  (lo_roll),
            .cex_i      (cex_in[n]),
            .wr_mode_i  (wr_mode),
            .wr_lo_i    (wr_lo),
            .wr_hi_i    (wr_hi),
            .wdata_i    (bus_wdata),
            .flag_clr_i (flag_clr[n]),
            .mode_o     (mode_vec[n]),
            .cmp_o      (cmp_vec[n]),
            .flag_o     (chan_flag[n]),
            .cex_o      (cex_out[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTL))
            bus_rdata = {ovf_flag, {(BYTE_W-2){1'b0}}, c_q.run};
        else if (bus_addr == ADDR_W'(ADR_CFG))
            bus_rdata = BYTE_W'({c_q.idle_stop, c_q.src, c_q.ovf_ie});
        else if (bus_addr == ADDR_W'(ADR_FLG))
            bus_rdata = BYTE_W'(chan_flag);
        else if (bus_addr == ADDR_W'(ADR_CNTL))
            bus_rdata = cnt[BYTE_W-1:0];
        else if (bus_addr == ADDR_W'(ADR_CNTH))
            bus_rdata = cnt[CNT_W-1:BYTE_W];
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n))
                bus_rdata = BYTE_W'(mode_vec[n]);
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 1))
                bus_rdata = cmp_vec[n][BYTE_W-1:0];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 2))
                bus_rdata = cmp_vec[n][CNT_W-1:BYTE_W];
        end
    end

    assign irq = (ovf_flag && c_q.ovf_ie) || (|(chan_flag & ie_vec));

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && chan_flag == '0) |-> !irq); // R12
    AST_FLAG_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flg && bus_wdata[0] && chan_flag[0]) |=> chan_flag[0]); // R11

endmodule

// File: tb/ctarr_top_tb_top.sv
`timescale 1ns/1ps
module ctarr_top_tb_top;
    localparam int NCH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic pclk_en = 1'b1;
    logic t0_ovf = 1'b0;
    logic ext_cnt = 1'b0;
    logic core_idle = 1'b0;
    logic [NCH-1:0] cex_in = '0;
    logic [NCH-1:0] cex_out, chan_flag;
    logic ovf_flag, irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ctarr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pclk_en(pclk_en),
        .t0_ovf(t0_ovf), .ext_cnt(ext_cnt), .core_idle(core_idle),
        .cex_in(cex_in), .cex_out(cex_out), .chan_flag(chan_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    // PWM vectors: {duty low byte, counter low byte, expected pin}
    localparam logic [16:0] PWM_VEC [6] = '{
        {8'h80, 8'h7F, 1'b0}, {8'h80, 8'h80, 1'b1}, {8'h00, 8'h00, 1'b1},
        {8'hFF, 8'hFE, 1'b0}, {8'hFF, 8'hFF, 1'b1}, {8'h10, 8'h05, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(5'd3, lo); rd(5'd4, hi);
        v = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(5'd3, v[7:0]); wr(5'd4, v[15:8]);
    endtask

    task automatic t0p();
        @(negedge clk); t0_ovf = 1'b1;
        @(posedge clk); #1 t0_ovf = 1'b0;
    endtask

    task automatic extp();
        @(negedge clk); ext_cnt = 1'b1;
        @(posedge clk);
        @(negedge clk); ext_cnt = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic setcex(input int idx, input logic v);
        @(negedge clk); cex_in[idx] = v;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, r); chk("R1 control", 16'(r), 16'h00);
        rd(5'd1, r); chk("R1 setup", 16'(r), 16'h00);
        rd_cnt(v);   chk("R1 counter", v, 16'h0000);
        chk("R1 pins/flags/irq", {cex_out, chan_flag, irq}, 16'h0);

        // R9 PWM level table on channel 0 (counter stopped)
        foreach (PWM_VEC[i]) begin
            wr(5'd3, PWM_VEC[i][8:1]);
            wr(5'd9, PWM_VEC[i][16:9]);
            wr(5'd8, 8'h42);
            chk($sformatf("R9 pwm vector %0d", i), 16'(cex_out[0]), 16'(PWM_VEC[i][0]));
        end
        wr(5'd8, 8'h00);

        // R2 R3 divide-by-2 source
        set_cnt(16'h0000);
        wr(5'd1, 8'h02);
        wr(5'd0, 8'h01);
        repeat (20) @(posedge clk);
        wr(5'd0, 8'h00);
        rd_cnt(v); chk("R2 div2 steps", v, 16'd10);

        // R2 divide-by-6 source
        set_cnt(16'h0000);
        wr(5'd1, 8'h00);
        wr(5'd0, 8'h01);
        repeat (20) @(posedge clk);
        wr(5'd0, 8'h00);
        rd_cnt(v); chk("R2 div6 steps", v, 16'd3);

        // R3 stopped counter ignores strobes
        wr(5'd1, 8'h04);
        t0p(); t0p(); t0p();
        rd_cnt(v); chk("R3 held while stopped", v, 16'd3);
        wr(5'd0, 8'h01);
        t0p(); t0p(); t0p(); t0p();
        rd_cnt(v); chk("R2 timer0 strobes", v, 16'd7);

        // R2 external rising edges
        wr(5'd1, 8'h06);
        extp(); extp(); extp();
        rd_cnt(v); chk("R2 external edges", v, 16'd10);

        // R4 idle hold
        wr(5'd1, 8'h0C);
        core_idle = 1'b1;
        t0p(); t0p();
        rd_cnt(v); chk("R4 halted in idle", v, 16'd10);
        wr(5'd1, 8'h04);
        t0p();
        rd_cnt(v); chk("R4 idle ignored when disabled", v, 16'd11);
        core_idle = 1'b0;

        // R5 wrap flag
        wr(5'd0, 8'h00);
        set_cnt(16'hFFFF);
        wr(5'd0, 8'h01);
        t0p();
        rd_cnt(v); chk("R5 wrap to zero", v, 16'h0000);
        rd(5'd0, r); chk("R5 flag set", 16'(r), 16'h81);
        chk("R12 irq masked", 16'(irq), 16'h0);
        wr(5'd1, 8'h05);
        chk("R12 irq on wrap", 16'(irq), 16'h1);
        wr(5'd0, 8'h81);
        rd(5'd0, r); chk("R5 write one keeps flag", 16'(r), 16'h81);
        wr(5'd0, 8'h01);
        rd(5'd0, r); chk("R5 write zero clears", 16'(r), 16'h01);
        chk("R12 irq after clear", 16'(irq), 16'h0);
        wr(5'd1, 8'h04);

        // R6 capture on channel 1
        wr(5'd0, 8'h00);
        set_cnt(16'h1234);
        wr(5'd11, 8'h20);
        setcex(1, 1'b1);
        rd(5'd12, r); v[7:0] = r; rd(5'd13, r); v[15:8] = r;
        chk("R6 rising capture", v, 16'h1234);
        chk("R6 capture flag", 16'(chan_flag), 16'b00010);
        wr(5'd2, 8'h00);
        set_cnt(16'h2222);
        setcex(1, 1'b0);
        rd(5'd12, r); v[7:0] = r; rd(5'd13, r); v[15:8] = r;
        chk("R6 falling ignored", v, 16'h1234);
        chk("R6 no flag on ignored edge", 16'(chan_flag), 16'h0);
        wr(5'd11, 8'h30);
        set_cnt(16'h3333);
        setcex(1, 1'b1);
        rd(5'd12, r); v[7:0] = r; rd(5'd13, r); v[15:8] = r;
        chk("R6 both edges rise", v, 16'h3333);
        set_cnt(16'h4444);
        setcex(1, 1'b0);
        rd(5'd12, r); v[7:0] = r; rd(5'd13, r); v[15:8] = r;
        chk("R6 both edges fall", v, 16'h4444);

        // R8 arming through byte writes, R7 match on channel 2
        wr(5'd14, 8'h0C);
        wr(5'd15, 8'h05);
        wr(5'd16, 8'h00);
        rd(5'd14, r); chk("R8 high byte arms", 16'(r), 16'h4C);
        wr(5'd15, 8'h05);
        rd(5'd14, r); chk("R8 low byte disarms", 16'(r), 16'h0C);
        wr(5'd16, 8'h00);
        set_cnt(16'h0000);
        wr(5'd0, 8'h01);
        t0p(); t0p(); t0p(); t0p();
        chk("R7 no match before target", {11'b0, chan_flag[2], 3'b0, cex_out[2]}, 16'h0);
        t0p();
        chk("R7 match flag", 16'(chan_flag[2]), 16'h1);
        chk("R7 toggle on match", 16'(cex_out[2]), 16'h1);
        wr(5'd0, 8'h00);

        // R10 PWM reload on channel 3
        wr(5'd19, 8'hC0);
        wr(5'd18, 8'h40);
        wr(5'd17, 8'h42);
        set_cnt(16'h00FE);
        chk("R9 pwm high", 16'(cex_out[3]), 16'h1);
        wr(5'd0, 8'h01);
        t0p();
        rd(5'd18, r); chk("R10 no reload before roll", 16'(r), 16'h40);
        t0p();
        rd(5'd18, r); chk("R10 reload at roll", 16'(r), 16'hC0);
        chk("R10 new duty drives pin", 16'(cex_out[3]), 16'h0);
        wr(5'd0, 8'h00);
        wr(5'd17, 8'h00);

        // R11 set beats clear in the same cycle
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'd2; bus_wdata = 8'h00; cex_in[1] = 1'b1;
        @(posedge clk); #1 bus_we = 1'b0;
        chk("R11 set wins, other cleared", 16'(chan_flag), 16'b00010);
        wr(5'd2, 8'hFF);
        chk("R11 write one no effect", 16'(chan_flag), 16'b00010);

        // R12 channel interrupt enable
        chk("R12 irq with enable off", 16'(irq), 16'h0);
        wr(5'd11, 8'h31);
        chk("R12 irq with enable on", 16'(irq), 16'h1);
        wr(5'd2, 8'h00);
        chk("R12 irq after flag clear", 16'(irq), 16'h0);

        done = 1'b1;
        finish_run();
    end
endmodule